// File: doc/BRIEF.md
# Paged microprocessor register port

This block is the host side of a bank of 8-bit control and status registers. A parallel, non-multiplexed bus with a 5-bit address, a chip select and two control pins reaches the registers in two steps. First, a write with address bit 4 low loads a page-select register with the data byte; the low four address bits play no part in that access. Afterwards, every access with address bit 4 high reaches register `addr[3:0]` inside the selected page. The page stays selected until it is written again, so software only revisits it when it moves to another page.

A strap input picks how the two control pins are read. With the strap high they are a separate active-low read strobe and an active-low write strobe. With the strap low they are a read/write level and an active-low data strobe. Writes take effect on the clock edge that first sees the write condition go away. The last address and data present while the write condition was active are the ones committed. Read data is combinational and is zero whenever no read is in progress. Pages 1 to 15 are backed by storage. Register indices given by a mask parameter are read-only status words in every page.

Top module: `pgreg_port`

## Requirements
- R1: After reset the page-select register holds 0x00, every writable register holds 0x00 and `rdata_o` is 0x00.
- R2: A write with `addr_i[4]`=0 loads the whole data byte into the page-select register whatever `addr_i[3:0]` is. A read with `addr_i[4]`=0 returns the page-select value.
- R3: Accesses with `addr_i[4]`=1 never change the page-select register.
- R4: With `addr_i[4]`=1 the access targets register `addr_i[3:0]` of the selected page. A write to one page leaves the same index in every other page unchanged.
- R5: With `bus_style_i`=1, a read is active while `cs_n_i`=0 and `ctl_a_i`=0, and a write is active while `cs_n_i`=0 and `ctl_b_i`=0. With `cs_n_i`=1 nothing is written.
- R6: With `bus_style_i`=0, `ctl_b_i` is an active-low data strobe and `ctl_a_i` is the direction: 1 reads, 0 writes. With the data strobe high nothing is read or written.
- R7: Register indices 14 and 15 (default mask 0xC000) are read-only in every page. They read `{page[3:0], index[3:0]}` and writes to them have no effect.
- R8: A page value of 0 or above 15 is latched and reads back through `addr_i[4]`=0. Register reads through it return 0x00 and register writes through it change nothing.
- R9: `rdata_o` is 0x00 whenever no read condition is active.
- R10: A write commits on the clock edge where the write condition is first seen inactive, using the address and data sampled on the last edge while it was active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_style_i | input | 1 | Strap: 1 separate read/write strobes, 0 direction level plus data strobe |
| cs_n_i | input | 1 | Active-low chip select |
| ctl_a_i | input | 1 | Read strobe (style 1, active low) or read/write level (style 0, 1 = read) |
| ctl_b_i | input | 1 | Write strobe (style 1, active low) or data strobe (style 0, active low) |
| addr_i | input | 5 | Bit 4 picks page-select (0) or paged register (1); bits 3:0 register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero outside a read |

## Verification
The bench writes the page-select register with nonzero low address bits. A design that decoded the full address would then miss the load or hit a register. It writes the same index in two pages and reads both back, which exposes a page decode that ignores the page value. Writes go to read-only indices, to page 0 and to page 0x20, and the bench then returns to a valid page to see that nothing leaked. It also changes the data while a write strobe is held, so a design that commits on the leading edge stores the stale byte. Both strap settings are used, including a mismatched pin pattern, which a swapped style decode would treat as a read.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned N_PAGES = 15;
  localparam logic [15:0] RO_IDX_MASK = 16'hC000;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pgreg_strobe.sv
module pgreg_strobe #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          style,
  input  logic          cs_n,
  input  logic          ctl_a,
  input  logic          ctl_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rd_act,
  output logic          commit,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_data
);
  logic wr_act, wr_act_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  // style 1: separate active-low strobes; style 0: level + data strobe
  always_comb begin
    if (style) begin
      rd_act = !cs_n && !ctl_a;
      wr_act = !cs_n && !ctl_b;
    end else begin
      rd_act = !cs_n && !ctl_b && ctl_a;
      wr_act = !cs_n && !ctl_b && !ctl_a;
    end
    addr_d = wr_act ? addr  : addr_q;
    data_d = wr_act ? wdata : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign commit   = wr_act_q && !wr_act;
  assign cmt_addr = addr_q;
  assign cmt_data = data_q;

  assert_commit_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank #(
  parameter int unsigned DW      = 8,
  parameter int unsigned IW      = 4,
  parameter int unsigned NPAGE   = 15,
  parameter logic [(1<<IW)-1:0] RO_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_page,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_page,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned NREG  = 1 << IW;
  localparam int unsigned NCELL = NPAGE * NREG;

  logic [NCELL-1:0][DW-1:0] cells;

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      if (RO_MASK[r]) begin : g_ro
        localparam int unsigned PATTERN = ((p + 1) << IW) | r;
        assign cells[p*NREG+r] = DW'(PATTERN);
      end else begin : g_rw
        logic          hit;
        logic [DW-1:0] q, d;
        always_comb begin
          hit = wr_en && (wr_page == DW'(p + 1)) && (wr_idx == IW'(r));
          d   = hit ? wr_data : q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= d;
        end
        assign cells[p*NREG+r] = q;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_page >= DW'(1) && rd_page <= DW'(NPAGE))
      rd_data = cells[(int'(rd_page) - 1) * NREG + int'(rd_idx)];
  end

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cells));
  assert_bad_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_page == '0 || wr_page > DW'(NPAGE))) |=> $stable(cells));
endmodule

// File: rtl/pgreg_port.sv
module pgreg_port
  import pgreg_pkg::*;
#(
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned IW      = IDX_W,
  parameter int unsigned NPAGE   = N_PAGES,
  parameter logic [(1<<IW)-1:0] RO_MASK = RO_IDX_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_style_i,
  input  logic          cs_n_i,
  input  logic          ctl_a_i,
  input  logic          ctl_b_i,
  input  logic [IW:0]   addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned AW = IW + 1;

  logic [1:0] rst_sync;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic          rd_act, commit;
  logic [AW-1:0] cmt_addr;
  logic [DW-1:0] cmt_data, bank_rd;
  logic [DW-1:0] page_q, page_d;
  logic          page_wr, reg_wr;

  pgreg_strobe #(.DW(DW), .AW(AW)) i_strobe (
    .clk(clk), .rst_n(rst_core_n), .style(bus_style_i), .cs_n(cs_n_i),
    .ctl_a(ctl_a_i), .ctl_b(ctl_b_i), .addr(addr_i), .wdata(wdata_i),
    .rd_act(rd_act), .commit(commit), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
  );

  always_comb begin
    page_wr = commit && !cmt_addr[AW-1];
    reg_wr  = commit &&  cmt_addr[AW-1];
    page_d  = page_wr ? cmt_data : page_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) page_q <= '0;
    else             page_q <= page_d;
  end

  pgreg_bank #(.DW(DW), .IW(IW), .NPAGE(NPAGE), .RO_MASK(RO_MASK)) i_bank (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr), .wr_page(page_q),
    .wr_idx(cmt_addr[IW-1:0]), .wr_data(cmt_data),
    .rd_page(page_q), .rd_idx(addr_i[IW-1:0]), .rd_data(bank_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_act) rdata_o = addr_i[IW] ? bank_rd : page_q;
  end

  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (commit && !cmt_addr[AW-1]) |=> page_q == $past(cmt_data));
  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(commit && !cmt_addr[AW-1]) |=> $stable(page_q));
endmodule

// File: tb/test_pgreg_port.sv
module test_pgreg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       style = 1'b1;
  logic       cs_n = 1'b1;
  logic       ctl_a = 1'b1;
  logic       ctl_b = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pgreg_port i_pgreg_port (
    .clk(clk), .rst_n(rst_n), .bus_style_i(style), .cs_n_i(cs_n),
    .ctl_a_i(ctl_a), .ctl_b_i(ctl_b), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cs_n = 1'b1; ctl_a = 1'b1; ctl_b = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; addr = a; wdata = d;
    if (style) begin ctl_a = 1'b1; ctl_b = 1'b0; end
    else       begin ctl_a = 1'b0; ctl_b = 1'b0; end
    @(posedge clk);
    idle();
    @(posedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0; addr = a;
    if (style) begin ctl_a = 1'b0; ctl_b = 1'b1; end
    else       begin ctl_a = 1'b1; ctl_b = 1'b0; end
    #1 check(req, rdata, exp);
    idle();
  endtask

  task automatic t_reset();
    #1 check("R1 rdata at reset", rdata, 8'h00);
    rd(5'h00, 8'h00, "R1 page reset");
    wr(5'h00, 8'h01);
    rd(5'h13, 8'h00, "R1 reg reset");
  endtask

  task automatic t_page_select();
    wr(5'h0A, 8'h03);
    rd(5'h07, 8'h03, "R2 page load, low bits ignored");
    wr(5'h12, 8'h5A);
    wr(5'h19, 8'hC3);
    rd(5'h12, 8'h5A, "R4/R5 page3 idx2");
    rd(5'h19, 8'hC3, "R4/R5 page3 idx9");
    rd(5'h00, 8'h03, "R3 page unchanged");
    wr(5'h00, 8'h05);
    wr(5'h12, 8'h11);
    rd(5'h12, 8'h11, "R4 page5 idx2");
    wr(5'h00, 8'h03);
    rd(5'h12, 8'h5A, "R4 page3 idx2 kept");
  endtask

  task automatic t_chip_select();
    wr(5'h12, 8'hFF, 1'b1);
    rd(5'h12, 8'h5A, "R5 write with cs_n high ignored");
    @(negedge clk);
    cs_n = 1'b1; ctl_a = 1'b0; addr = 5'h12;
    #1 check("R9 rdata zero with cs_n high", rdata, 8'h00);
    idle();
  endtask

  task automatic t_readonly();
    wr(5'h1E, 8'h00);
    rd(5'h1E, 8'h3E, "R7 page3 idx14");
    wr(5'h00, 8'h05);
    wr(5'h1F, 8'h00);
    rd(5'h1F, 8'h5F, "R7 page5 idx15");
  endtask

  task automatic t_bad_page();
    wr(5'h00, 8'h20);
    rd(5'h00, 8'h20, "R8 out-of-range page latched");
    wr(5'h12, 8'h77);
    rd(5'h12, 8'h00, "R8 read through page 0x20");
    wr(5'h00, 8'h00);
    wr(5'h12, 8'h66);
    rd(5'h1E, 8'h00, "R8 read through page 0");
    wr(5'h00, 8'h03);
    rd(5'h12, 8'h5A, "R8 no write leaked");
  endtask

  task automatic t_motorola();
    style = 1'b0;
    wr(5'h00, 8'h07);
    wr(5'h14, 8'hA5);
    rd(5'h14, 8'hA5, "R6 level+strobe write/read");
    rd(5'h00, 8'h07, "R6 page read");
    @(negedge clk);
    cs_n = 1'b0; ctl_a = 1'b0; ctl_b = 1'b1; addr = 5'h14;
    #1 check("R6/R9 strobe high no read", rdata, 8'h00);
    idle();
    @(posedge clk);
    rd(5'h14, 8'hA5, "R6 strobe high no write");
    style = 1'b1;
  endtask

  task automatic t_late_commit();
    @(negedge clk);
    cs_n = 1'b0; addr = 5'h16; wdata = 8'h3C; ctl_a = 1'b1; ctl_b = 1'b0;
    @(negedge clk);
    wdata = 8'hD2;
    @(negedge clk);
    cs_n = 1'b1; ctl_b = 1'b1;
    @(posedge clk);
    rd(5'h16, 8'hD2, "R10 last data before release");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_page_select();
    t_chip_select();
    t_readonly();
    t_bad_page();
    t_motorola();
    t_late_commit();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule